// File: doc/BRIEF.md
# Configurable GPIO Routing Matrix

This block sits between a row of I/O pads and the input and output signals of the on-chip peripherals, and it decides which pad feeds which peripheral input and which peripheral output drives which pad. Every peripheral input can take any pad as its source, or a constant high or low level. It can instead take a fixed pad through a direct path that bypasses all processing. Every pad can be driven by any peripheral output through the matrix, or by a fixed peripheral output through its direct path. Matrix routes can invert the signal. Matrix input routes can also add a two-flop synchroniser and a glitch filter. Each pad carries input-enable, output-enable, pull-up and pull-down controls. These are presented at the pad interface, and the read value of a pad is forced to 0 while its input is disabled.

Software configures the block through a single write port. Address bit 7 selects the region: 0 for pad words and 1 for input-route words. Address bits 5:0 give the entry index, and address bit 6 must be 0. A write to an index beyond the configured count is dropped. A pad word holds input enable [0], output enable [1], pull-up [2], pull-down [3], matrix-versus-direct output select [4] (1 = matrix), output invert [5] and the peripheral output number [13:8]. An input-route word holds the source code [5:0], direct-path select [6] (1 = direct), invert [7], synchroniser enable [8] and filter enable [9]. Source codes below the pad count name a pad. Code 0x38 is constant 1, code 0x39 is constant 0, and any other code reads as 0. The direct path of input i is pad i mod the pad count. The direct path of pad p is peripheral output p mod the output count.

Each input route owns a small filter state machine with two states. In FLT_HOLD the filtered level equals the incoming level. A differing sample takes the transition hold-to-qualify into FLT_QUAL with the run count at 1. In FLT_QUAL each further differing sample adds to the count. The transition qualify-to-hold-accept adopts the new level on the third consecutive differing sample. The transition qualify-to-hold-reject returns to FLT_HOLD without change when the input falls back to the current level.

Top module: `gpio_route_matrix`

## Requirements
- R1: After reset every pad has input, output, pull-up and pull-down enables cleared, and every peripheral input reads 0 (matrix, constant-0 code 0x39, no inversion).
- R2: A pad whose input enable (pad word bit 0) is 0 reads as 0 on both the matrix and the direct path, whatever its pin level.
- R3: pad_oe follows the pad's output-enable bit (pad word bit 1), and pad_out is 0 whenever pad_oe is 0.
- R4: pad_pu and pad_pd follow pad word bits 2 and 3, independently of each other.
- R5: A matrix input route with source code k below the pad count follows pad k, and several inputs can follow the same pad at once.
- R6: Source code 0x38 gives constant 1, code 0x39 gives constant 0, and any other code at or above the pad count gives 0.
- R7: With input-route bit 6 set, input i follows pad i mod the pad count in the same cycle, and the invert, synchroniser and filter bits have no effect.
- R8: Input-route bit 7 inverts a matrix input route.
- R9: With input-route bit 8 set, a matrix input reflects a pad change two clock edges later.
- R10: With input-route bit 9 set, a new level passes only after being sampled on three consecutive edges, so a level held for two cycles is not passed.
- R11: A pad with pad word bit 4 set drives peripheral output number [13:8], one output can drive several pads, and pad word bit 5 inverts that route.
- R12: A pad with pad word bit 4 clear drives peripheral output p mod the output count, and bit 5 has no effect.
- R13: A pad with output and input enabled together feeds its driven value back to any input routed from it.
- R14: A configuration write changes the outputs from the next clock edge, and writes to an out-of-range index or with address bit 6 set change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration address (region, index) |
| cfg_wdata | input | 16 | Configuration write data |
| pad_in | input | NUM_PADS | Level seen at each pad |
| pad_out | output | NUM_PADS | Value each pad drives |
| pad_oe | output | NUM_PADS | Pad output enable (0 = high impedance) |
| pad_pu | output | NUM_PADS | Weak pull-up enable per pad |
| pad_pd | output | NUM_PADS | Weak pull-down enable per pad |
| per_out | input | NUM_OUT | Peripheral output signals |
| per_in | output | NUM_IN | Peripheral input signals |

## Verification
Route results without the synchroniser or filter appear in the same cycle as the pad or peripheral change. A configuration write shows up in the cycle after its strobe. A synchronised input is due two edges after its pad change, and a filtered input three edges after it. The driver stamps each expected value with the cycle in which it falls due, including the old value one cycle before each deadline. The monitor compares values at the falling edge of exactly that cycle, so early and late changes are both caught.

// File: rtl/gpio_mtx_pkg.sv
package gpio_mtx_pkg;

    localparam int          SRC_W        = 6;
    localparam logic [5:0]  SRC_CONST_HI = 6'h38;
    localparam logic [5:0]  SRC_CONST_LO = 6'h39;

    typedef struct packed {
        logic [SRC_W-1:0] osel;
        logic             oinv;
        logic             omtx;
        logic             pd;
        logic             pu;
        logic             oe;
        logic             ie;
    } pad_cfg_t;

    typedef struct packed {
        logic             filt;
        logic             sync;
        logic             inv;
        logic             direct;
        logic [SRC_W-1:0] src;
    } in_cfg_t;

    typedef enum logic [0:0] {
        FLT_HOLD = 1'b0,
        FLT_QUAL = 1'b1
    } flt_state_e;

    localparam in_cfg_t IN_CFG_RST = '{filt: 1'b0, sync: 1'b0, inv: 1'b0,
                                       direct: 1'b0, src: SRC_CONST_LO};

endpackage

// File: rtl/gpio_mtx_cfg.sv
module gpio_mtx_cfg
    import gpio_mtx_pkg::*;
#(
    parameter int NP = 8,
    parameter int NI = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [7:0]  addr,
    input  logic [15:0] wdata,
    output pad_cfg_t    pad_cfg [NP],
    output in_cfg_t     in_cfg  [NI]
);

    logic pad_region;
    logic in_region;
    logic unused_bits;

    assign pad_region  = we && !addr[7] && !addr[6];
    assign in_region   = we &&  addr[7] && !addr[6];
    assign unused_bits = ^{wdata[15:14], wdata[7:6]};

    for (genvar p = 0; p < NP; p++) begin : g_pad
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pad_cfg[p] <= '0;
            end else if (pad_region && addr[5:0] == 6'(p)) begin
                pad_cfg[p] <= pad_cfg_t'({wdata[13:8], wdata[5:0]});
            end
        end
    end

    for (genvar i = 0; i < NI; i++) begin : g_in
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                in_cfg[i] <= IN_CFG_RST;
            end else if (in_region && addr[5:0] == 6'(i)) begin
                in_cfg[i] <= in_cfg_t'(wdata[9:0]);
            end
        end
    end

endmodule

// File: rtl/gpio_mtx_glitch_flt.sv
module gpio_mtx_glitch_flt
    import gpio_mtx_pkg::*;
#(
    parameter int FLT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    localparam int CNT_W = $clog2(FLT_LEN + 1);

    flt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             lvl_q, lvl_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_HOLD;
            cnt_q   <= '0;
            lvl_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            lvl_q   <= lvl_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        lvl_d   = lvl_q;
        unique case (state_q)
            FLT_HOLD: begin
                if (d != lvl_q) begin
                    if (FLT_LEN <= 1) begin
                        lvl_d = d;
                    end else begin
                        state_d = FLT_QUAL;
                        cnt_d   = CNT_W'(1);
                    end
                end
            end
            FLT_QUAL: begin
                if (d == lvl_q) begin
                    state_d = FLT_HOLD;
                    cnt_d   = '0;
                end else if (cnt_q == CNT_W'(FLT_LEN - 1)) begin
                    state_d = FLT_HOLD;
                    cnt_d   = '0;
                    lvl_d   = d;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            default: begin
                state_d = FLT_HOLD;
                cnt_d   = '0;
            end
        endcase
    end

    assign q = lvl_q;

endmodule

// File: rtl/gpio_mtx_in_route.sv
module gpio_mtx_in_route
    import gpio_mtx_pkg::*;
#(
    parameter int NP      = 8,
    parameter int FLT_LEN = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  in_cfg_t       cfg,
    input  logic [NP-1:0] pad_rd,
    input  logic          direct_bit,
    output logic          per_in
);

    logic mtx_raw;
    logic sync_a, sync_b;
    logic sync_out;
    logic flt_q;
    logic flt_out;

    always_comb begin
        mtx_raw = 1'b0;
        if (cfg.src == SRC_CONST_HI) begin
            mtx_raw = 1'b1;
        end else begin
            for (int k = 0; k < NP; k++) begin
                if (cfg.src == SRC_W'(k)) mtx_raw = pad_rd[k];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_a <= 1'b0;
            sync_b <= 1'b0;
        end else begin
            sync_a <= mtx_raw;
            sync_b <= sync_a;
        end
    end

    assign sync_out = cfg.sync ? sync_b : mtx_raw;

    gpio_mtx_glitch_flt #(.FLT_LEN(FLT_LEN)) u_flt (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sync_out),
        .q     (flt_q)
    );

    assign flt_out = cfg.filt ? flt_q : sync_out;
    assign per_in  = cfg.direct ? direct_bit : (flt_out ^ cfg.inv);

endmodule

// File: rtl/gpio_mtx_out_route.sv
module gpio_mtx_out_route
    import gpio_mtx_pkg::*;
#(
    parameter int NO = 4
) (
    input  pad_cfg_t      cfg,
    input  logic [NO-1:0] per_out,
    input  logic          direct_bit,
    output logic          pad_out
);

    logic mtx_sel;

    always_comb begin
        mtx_sel = 1'b0;
        for (int k = 0; k < NO; k++) begin
            if (cfg.osel == SRC_W'(k)) mtx_sel = per_out[k];
        end
    end

    assign pad_out = cfg.oe & (cfg.omtx ? (mtx_sel ^ cfg.oinv) : direct_bit);

endmodule

// File: rtl/gpio_route_matrix.sv
module gpio_route_matrix
    import gpio_mtx_pkg::*;
#(
    parameter int NUM_PADS = 8,
    parameter int NUM_IN   = 4,
    parameter int NUM_OUT  = 4,
    parameter int FLT_LEN  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [7:0]          cfg_addr,
    input  logic [15:0]         cfg_wdata,
    input  logic [NUM_PADS-1:0] pad_in,
    output logic [NUM_PADS-1:0] pad_out,
    output logic [NUM_PADS-1:0] pad_oe,
    output logic [NUM_PADS-1:0] pad_pu,
    output logic [NUM_PADS-1:0] pad_pd,
    input  logic [NUM_OUT-1:0]  per_out,
    output logic [NUM_IN-1:0]   per_in
);

    pad_cfg_t            pad_cfg [NUM_PADS];
    in_cfg_t             in_cfg  [NUM_IN];
    logic [NUM_PADS-1:0] pad_rd;

    gpio_mtx_cfg #(.NP(NUM_PADS), .NI(NUM_IN)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .pad_cfg (pad_cfg),
        .in_cfg  (in_cfg)
    );

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        assign pad_rd[p] = pad_in[p] & pad_cfg[p].ie;
        assign pad_oe[p] = pad_cfg[p].oe;
        assign pad_pu[p] = pad_cfg[p].pu;
        assign pad_pd[p] = pad_cfg[p].pd;

        gpio_mtx_out_route #(.NO(NUM_OUT)) u_out (
            .cfg        (pad_cfg[p]),
            .per_out    (per_out),
            .direct_bit (per_out[p % NUM_OUT]),
            .pad_out    (pad_out[p])
        );
    end

    for (genvar i = 0; i < NUM_IN; i++) begin : g_in
        gpio_mtx_in_route #(.NP(NUM_PADS), .FLT_LEN(FLT_LEN)) u_in (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg        (in_cfg[i]),
            .pad_rd     (pad_rd),
            .direct_bit (pad_rd[i % NUM_PADS]),
            .per_in     (per_in[i])
        );
    end

endmodule

// File: rtl/gpio_route_matrix_chk.sv
module gpio_route_matrix_chk
    import gpio_mtx_pkg::*;
#(
    parameter int NP = 8,
    parameter int NI = 4,
    parameter int NO = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic [7:0]    cfg_addr,
    input logic [15:0]   cfg_wdata,
    input logic [NP-1:0] pad_out,
    input logic [NP-1:0] pad_oe,
    input logic [NP-1:0] pad_pu,
    input logic [NO-1:0] per_out,
    input logic [NI-1:0] per_in,
    input pad_cfg_t      pad_cfg [NP],
    input in_cfg_t       in_cfg  [NI]
);

    for (genvar p = 0; p < NP; p++) begin : g_pad_chk
        // R3
        oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !pad_oe[p] |-> !pad_out[p]);

        // R12
        direct_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pad_cfg[p].oe && !pad_cfg[p].omtx) |-> (pad_out[p] == per_out[p % NO]));

        // R14
        cfg_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_addr == 8'(p)) |=>
                (pad_oe[p] == $past(cfg_wdata[1]) && pad_pu[p] == $past(cfg_wdata[2])));
    end

    for (genvar i = 0; i < NI; i++) begin : g_in_chk
        // R2
        direct_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_cfg[i].direct && !pad_cfg[i % NP].ie) |-> !per_in[i]);

        // R6
        const_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!in_cfg[i].direct && in_cfg[i].src == SRC_CONST_HI && !in_cfg[i].inv &&
             !in_cfg[i].sync && !in_cfg[i].filt) |-> per_in[i]);
    end

endmodule

bind gpio_route_matrix gpio_route_matrix_chk #(
    .NP (NUM_PADS),
    .NI (NUM_IN),
    .NO (NUM_OUT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_pu    (pad_pu),
    .per_out   (per_out),
    .per_in    (per_in),
    .pad_cfg   (pad_cfg),
    .in_cfg    (in_cfg)
);

// File: tb/tb_gpio_route_matrix.sv
`timescale 1ns/1ps
module tb_gpio_route_matrix;

    localparam int NP = 8;
    localparam int NI = 4;
    localparam int NO = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [7:0]    cfg_addr = '0;
    logic [15:0]   cfg_wdata = '0;
    logic [NP-1:0] ext = '0;
    logic [NP-1:0] pad_in, pad_out, pad_oe, pad_pu, pad_pd;
    logic [NO-1:0] per_out = '0;
    logic [NI-1:0] per_in;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // pad model: a driven pad shows its own output, otherwise the external level
    assign pad_in = pad_oe & pad_out | ~pad_oe & ext;

    gpio_route_matrix dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
        .per_out(per_out), .per_in(per_in)
    );

    typedef struct {
        int    due;
        int    kind;
        int    idx;
        logic  val;
        string tag;
    } exp_t;
    exp_t sbq[$];

    function automatic logic probe(int kind, int idx);
        case (kind)
            0: return per_in[idx];
            1: return pad_out[idx];
            2: return pad_oe[idx];
            3: return pad_pu[idx];
            default: return pad_pd[idx];
        endcase
    endfunction

    always @(negedge clk) begin
        for (int i = sbq.size() - 1; i >= 0; i--) begin
            if (sbq[i].due == cyc) begin
                logic act;
                act = probe(sbq[i].kind, sbq[i].idx);
                checks++;
                if (act !== sbq[i].val) begin
                    errors++;
                    $display("FAIL %s kind=%0d idx=%0d cycle=%0d actual=%b expected=%b",
                             sbq[i].tag, sbq[i].kind, sbq[i].idx, cyc, act, sbq[i].val);
                end
                sbq.delete(i);
            end
        end
    end

    task automatic expect_at(int dly, int kind, int idx, logic val, string tag);
        exp_t e;
        e.due = cyc + dly; e.kind = kind; e.idx = idx; e.val = val; e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [7:0] a, logic [15:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick(1);
        cfg_we = 1'b0;
    endtask

    function automatic logic [15:0] pad_w(bit ie, bit oe, bit pu, bit pd,
                                          bit omtx, bit oinv, int osel);
        return {2'b00, 6'(osel), 2'b00, oinv, omtx, pd, pu, oe, ie};
    endfunction

    function automatic logic [15:0] in_w(int src, bit direct, bit inv, bit sync, bit filt);
        return {6'b0, filt, sync, inv, direct, 6'(src)};
    endfunction

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        ext = 8'hFF;
        // R1: reset state
        for (int i = 0; i < NI; i++) expect_at(0, 0, i, 1'b0, "R1");
        for (int p = 0; p < NP; p += 3) begin
            expect_at(0, 2, p, 1'b0, "R1");
            expect_at(0, 3, p, 1'b0, "R1");
            expect_at(0, 4, p, 1'b0, "R1");
        end
        tick(1);

        // R14: out-of-range and bad-region writes change nothing
        wr(8'h09, pad_w(1, 1, 1, 1, 0, 0, 0));
        wr(8'h85, in_w(8'h38, 0, 0, 0, 0));
        wr(8'h40, pad_w(1, 1, 1, 1, 0, 0, 0));
        wr(8'hC0, in_w(8'h38, 0, 0, 0, 0));
        for (int p = 0; p < NP; p++) expect_at(0, 3, p, 1'b0, "R14");
        for (int i = 0; i < NI; i++) expect_at(0, 0, i, 1'b0, "R14");
        tick(1);

        // R14 / R4: write visible from the next edge; pulls independent
        cfg_we = 1'b1; cfg_addr = 8'h02; cfg_wdata = pad_w(0, 0, 1, 0, 0, 0, 0);
        expect_at(0, 3, 2, 1'b0, "R14");
        expect_at(1, 3, 2, 1'b1, "R14");
        tick(1);
        cfg_we = 1'b0;
        wr(8'h03, pad_w(0, 0, 0, 1, 0, 0, 0));
        expect_at(0, 3, 2, 1'b1, "R4");
        expect_at(0, 4, 2, 1'b0, "R4");
        expect_at(0, 3, 3, 1'b0, "R4");
        expect_at(0, 4, 3, 1'b1, "R4");
        tick(1);

        // R5: one pad fans out to two inputs
        wr(8'h01, pad_w(1, 0, 0, 0, 0, 0, 0));
        wr(8'h80, in_w(1, 0, 0, 0, 0));
        wr(8'h81, in_w(1, 0, 0, 0, 0));
        ext[1] = 1'b1;
        expect_at(0, 0, 0, 1'b1, "R5");
        expect_at(0, 0, 1, 1'b1, "R5");
        tick(1);
        ext[1] = 1'b0;
        expect_at(0, 0, 0, 1'b0, "R5");
        expect_at(0, 0, 1, 1'b0, "R5");
        tick(1);
        // R2: disabled input reads 0
        ext[1] = 1'b1;
        wr(8'h01, pad_w(0, 0, 0, 0, 0, 0, 0));
        expect_at(0, 0, 0, 1'b0, "R2");
        expect_at(0, 0, 1, 1'b0, "R2");
        tick(1);

        // R6: constant codes and unknown code
        wr(8'h82, in_w(8'h38, 0, 0, 0, 0));
        expect_at(0, 0, 2, 1'b1, "R6");
        tick(1);
        wr(8'h82, in_w(8'h39, 0, 0, 0, 0));
        expect_at(0, 0, 2, 1'b0, "R6");
        tick(1);
        wr(8'h82, in_w(8'h20, 0, 0, 0, 0));
        expect_at(0, 0, 2, 1'b0, "R6");
        tick(1);

        // R8: inversion on matrix path
        wr(8'h01, pad_w(1, 0, 0, 0, 0, 0, 0));
        wr(8'h80, in_w(1, 0, 1, 0, 0));
        ext[1] = 1'b1;
        expect_at(0, 0, 0, 1'b0, "R8");
        tick(1);
        ext[1] = 1'b0;
        expect_at(0, 0, 0, 1'b1, "R8");
        tick(1);

        // R7: direct path ignores invert/sync/filter; R2 gating on direct path
        wr(8'h03, pad_w(1, 0, 0, 0, 0, 0, 0));
        wr(8'h83, in_w(8'h38, 1, 1, 1, 1));
        ext[3] = 1'b1;
        expect_at(0, 0, 3, 1'b1, "R7");
        tick(1);
        ext[3] = 1'b0;
        expect_at(0, 0, 3, 1'b0, "R7");
        tick(1);
        ext[3] = 1'b1;
        wr(8'h03, pad_w(0, 0, 0, 0, 0, 0, 0));
        expect_at(0, 0, 3, 1'b0, "R2");
        tick(1);

        // R9: synchroniser delay of two edges
        wr(8'h80, in_w(1, 0, 0, 1, 0));
        ext[1] = 1'b0;
        tick(4);
        ext[1] = 1'b1;
        expect_at(0, 0, 0, 1'b0, "R9");
        expect_at(1, 0, 0, 1'b0, "R9");
        expect_at(2, 0, 0, 1'b1, "R9");
        tick(3);

        // R10: two-cycle glitch rejected, three-cycle level accepted
        wr(8'h80, in_w(1, 0, 0, 0, 1));
        ext[1] = 1'b0;
        tick(5);
        ext[1] = 1'b1;
        for (int d = 0; d < 6; d++) expect_at(d, 0, 0, 1'b0, "R10");
        tick(2);
        ext[1] = 1'b0;
        tick(4);
        ext[1] = 1'b1;
        expect_at(2, 0, 0, 1'b0, "R10");
        expect_at(3, 0, 0, 1'b1, "R10");
        tick(4);

        // R11: one peripheral output to two pads, second one inverted
        per_out = 4'b0100;
        wr(8'h04, pad_w(0, 1, 0, 0, 1, 0, 2));
        wr(8'h05, pad_w(0, 1, 0, 0, 1, 1, 2));
        expect_at(0, 1, 4, 1'b1, "R11");
        expect_at(0, 1, 5, 1'b0, "R11");
        expect_at(0, 2, 4, 1'b1, "R3");
        tick(1);
        per_out = 4'b0000;
        expect_at(0, 1, 4, 1'b0, "R11");
        expect_at(0, 1, 5, 1'b1, "R11");
        tick(1);

        // R12: direct output path (pad 6 takes output 2), invert ignored
        wr(8'h06, pad_w(0, 1, 0, 0, 0, 1, 0));
        per_out = 4'b0100;
        expect_at(0, 1, 6, 1'b1, "R12");
        tick(1);
        per_out = 4'b0000;
        expect_at(0, 1, 6, 1'b0, "R12");
        tick(1);

        // R3: output disabled pad is not driven
        wr(8'h07, pad_w(0, 0, 0, 0, 1, 0, 2));
        per_out = 4'b0100;
        expect_at(0, 1, 7, 1'b0, "R3");
        expect_at(0, 2, 7, 1'b0, "R3");
        tick(1);

        // R13: loopback through pad 0 to two inputs, one inverted
        ext[0] = 1'b0;
        wr(8'h00, pad_w(1, 1, 0, 0, 1, 0, 1));
        wr(8'h81, in_w(0, 0, 0, 0, 0));
        wr(8'h82, in_w(0, 0, 1, 0, 0));
        per_out = 4'b0010;
        expect_at(0, 0, 1, 1'b1, "R13");
        expect_at(0, 0, 2, 1'b0, "R13");
        tick(1);
        ext[0] = 1'b1;
        per_out = 4'b0000;
        expect_at(0, 0, 1, 1'b0, "R13");
        expect_at(0, 0, 2, 1'b1, "R13");
        tick(3);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired at cycle %0d actual=running expected=done", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule